// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces one column address per clock for each beat of an SDRAM read or write burst. A programming word, written over a simple load strobe, sets the burst length, the wrap order and the read latency. A command input then starts, restarts or ends bursts. Each beat appears on registered outputs with a valid flag, a last-beat flag and a write flag.

Within one burst the address wraps inside a block whose size is the burst length and which is aligned to it. The wrap is either a plain increment or an XOR of the start with the beat index. In full-page mode the burst walks the whole row and only ends on another command. A separate delay line replays each read beat on the read-data side once the programmed CAS latency has passed, so a controller can line up returning data with its column.

Top module: `sdr_burst_colgen`

## Requirements
- R1: While reset is high and after it is released, `col_valid`, `col_last`, `rd_valid` and `mode_err` are low. The settings default to burst length 1, sequential order, CAS latency 2 and single-write mode off.
- R2: When `mode_load` is sampled high, `mode_word` is decoded and applies to commands sampled on later edges. The fields are:
  - bits [2:0] give the length: 000 = 1, 001 = 2, 010 = 4, 011 = 8, 111 = full page.
  - bit 3 gives the order: 0 = sequential, 1 = interleave.
  - bits [6:4] give the CAS latency: 010 = 2, 011 = 3.
  - bit 9 turns on single-write mode.
- R3: A word with a reserved length code, full page combined with interleave, a reserved latency code, or nonzero bits [8:7] leaves every setting unchanged. In that case `mode_err` is high for exactly the one cycle after the load edge.
- R4: `cmd` values are 001 = read, 010 = write, 011 = burst stop and 100 = precharge; every other value is a no-op. For a read or write, beat 0 is presented with `col_valid` high and `col_addr` equal to `cmd_col` in the cycle after the sampling edge. The following beats come one per cycle with no gap, and `col_write` is high on write beats.
- R5: Sequential order: beat i carries start + i modulo the burst length in the low bits (start 5, length 8 gives 5,6,7,0,1,2,3,4).
- R6: Interleave order: beat i carries start XOR i in the low bits (start 2, length 8 gives 2,3,0,1,6,7,4,5).
- R7: Column bits above the burst block equal those of `cmd_col` on every beat of the burst.
- R8: `col_last` is high only on the final beat. `col_valid` is low in the following cycle unless a new read or write was sampled. A length-1 burst is a single beat with `col_last` high.
- R9: A full-page burst steps through all 2^COL_W columns sequentially and wraps around. It never raises `col_last` and continues until a stop, precharge, read or write is sampled.
- R10: A read or write sampled during a burst discards the remaining beats. It starts a complete new burst at its own column in the next cycle.
- R11: After a stop or precharge is sampled, `col_valid` is low in the next cycle and no further beats of that burst appear.
- R12: In single-write mode a write is one beat with `col_last` high, whatever the length setting. Reads still use the full length.
- R13: For each read beat presented in cycle k, `rd_valid` is high in cycle k+CL with `rd_col` equal to that beat's column and `rd_last` equal to its last flag. Write beats never produce `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_load | input | 1 | Load strobe for `mode_word` |
| mode_word | input | 10 | Programming word (fields in R2) |
| cmd | input | 3 | Command code (R4) |
| cmd_col | input | COL_W | Start column for a read or write |
| col_addr | output | COL_W | Column of the current beat |
| col_valid | output | 1 | A beat is presented this cycle |
| col_last | output | 1 | Current beat is the final one |
| col_write | output | 1 | Current beat belongs to a write |
| rd_valid | output | 1 | Read data for a beat is due this cycle |
| rd_col | output | COL_W | Column of that read beat |
| rd_last | output | 1 | That read beat was the final one |
| mode_err | output | 1 | One-cycle pulse on a rejected programming word |

## Verification
The latency and single-write properties read the decoded settings and assume they stay put while a burst or its read pipeline is in flight. The stimulus therefore loads a new word only after the previous burst and its delayed read beats have fully drained. The bench also never pairs a load with a command on the same edge. Command codes outside the four defined values are assumed to act as no-ops and are not otherwise relied on.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  localparam int MODE_W = 10;
  localparam int MAX_CL = 3;
  localparam int CMD_W  = 3;

  localparam logic [CMD_W-1:0] CMD_RD   = 3'd1;
  localparam logic [CMD_W-1:0] CMD_WR   = 3'd2;
  localparam logic [CMD_W-1:0] CMD_STOP = 3'd3;
  localparam logic [CMD_W-1:0] CMD_PRE  = 3'd4;

  typedef struct packed {
    logic       full;     // full-page burst
    logic       ilv;      // interleave order
    logic [1:0] len_log;  // log2 of burst length (1..8)
    logic       cas3;     // CAS latency 3 when set, else 2
    logic       wr_one;   // writes are single beats
  } cfg_t;

  localparam cfg_t CFG_RESET = '0;

endpackage

// File: rtl/colgen_mode_dec.sv
module colgen_mode_dec
  import colgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [MODE_W-1:0] word,
  output cfg_t              cfg,
  output logic              err
);

  logic [2:0] len_code;
  logic [2:0] lat_code;
  logic       len_ok;
  logic       lat_ok;
  logic       opm_ok;
  logic       word_ok;
  cfg_t       cfg_new;

  always_comb begin
    len_code = word[2:0];
    lat_code = word[6:4];
    len_ok   = (len_code[2] == 1'b0) || (len_code == 3'b111 && !word[3]);
    lat_ok   = (lat_code == 3'b010) || (lat_code == 3'b011);
    opm_ok   = (word[8:7] == 2'b00);
    word_ok  = len_ok && lat_ok && opm_ok;

    cfg_new.full    = (len_code == 3'b111);
    cfg_new.ilv     = word[3];
    cfg_new.len_log = len_code[1:0];
    cfg_new.cas3    = lat_code[0];
    cfg_new.wr_one  = word[9];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= CFG_RESET;
      err <= 1'b0;
    end else begin
      err <= load && !word_ok;
      if (load && word_ok) cfg <= cfg_new;
    end
  end

endmodule

// File: rtl/colgen_seq.sv
module colgen_seq
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_rd,
  input  logic             go_wr,
  input  logic             halt,
  input  logic [COL_W-1:0] start_col,
  input  cfg_t             cfg,
  output logic [COL_W-1:0] col_addr,
  output logic             col_valid,
  output logic             col_last,
  output logic             col_write
);

  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] idx_q;
  logic [COL_W-1:0] mask_q;
  logic             full_q;
  logic             ilv_q;
  logic             wr_q;
  logic             active_q;

  logic             go;
  logic             new_single;
  logic             new_full;
  logic [COL_W-1:0] new_mask;
  logic [COL_W-1:0] low_step;
  logic [COL_W-1:0] addr_step;
  logic             step_last;

  always_comb begin
    go         = go_rd || go_wr;
    new_single = go_wr && cfg.wr_one;
    new_full   = cfg.full && !new_single;
    if (new_full)        new_mask = '1;
    else if (new_single) new_mask = '0;
    else                 new_mask = COL_W'((1 << cfg.len_log) - 1);

    low_step  = ilv_q ? (base_q ^ idx_q) : (base_q + idx_q);
    addr_step = (base_q & ~mask_q) | (low_step & mask_q);
    step_last = !full_q && (idx_q == mask_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= '0;
      idx_q     <= '0;
      mask_q    <= '0;
      full_q    <= 1'b0;
      ilv_q     <= 1'b0;
      wr_q      <= 1'b0;
      active_q  <= 1'b0;
      col_addr  <= '0;
      col_valid <= 1'b0;
      col_last  <= 1'b0;
      col_write <= 1'b0;
    end else if (go) begin
      base_q    <= start_col;
      idx_q     <= COL_W'(1);
      mask_q    <= new_mask;
      full_q    <= new_full;
      ilv_q     <= cfg.ilv && !new_full;
      wr_q      <= go_wr;
      active_q  <= new_full || (new_mask != '0);
      col_addr  <= start_col;
      col_valid <= 1'b1;
      col_last  <= !new_full && (new_mask == '0);
      col_write <= go_wr;
    end else if (halt) begin
      active_q  <= 1'b0;
      col_valid <= 1'b0;
      col_last  <= 1'b0;
      col_write <= 1'b0;
    end else if (active_q) begin
      col_addr  <= addr_step;
      col_valid <= 1'b1;
      col_last  <= step_last;
      col_write <= wr_q;
      idx_q     <= idx_q + COL_W'(1);
      active_q  <= !step_last;
    end else begin
      col_valid <= 1'b0;
      col_last  <= 1'b0;
      col_write <= 1'b0;
    end
  end

endmodule

// File: rtl/colgen_lat_pipe.sv
module colgen_lat_pipe #(
  parameter int W     = 9,
  parameter int DEPTH = 3,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [W-1:0]     in_dat,
  input  logic [SEL_W-1:0] tap,
  output logic             out_vld,
  output logic [W-1:0]     out_dat
);

  logic [DEPTH-1:0] vld_q;
  logic [W-1:0]     dat_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= {vld_q[DEPTH-2:0], in_vld};
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) dat_q[0] <= in_dat;
    end else begin : g_body
      always_ff @(posedge clk) dat_q[g] <= dat_q[g-1];
    end
  end

  assign out_vld = vld_q[tap];
  assign out_dat = dat_q[tap];

endmodule

// File: rtl/sdr_burst_colgen.sv
module sdr_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_load,
  input  logic [MODE_W-1:0] mode_word,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [COL_W-1:0]  cmd_col,
  output logic [COL_W-1:0]  col_addr,
  output logic              col_valid,
  output logic              col_last,
  output logic              col_write,
  output logic              rd_valid,
  output logic [COL_W-1:0]  rd_col,
  output logic              rd_last,
  output logic              mode_err
);

  localparam int SEL_W = $clog2(MAX_CL);
  localparam int PW    = COL_W + 1;

  cfg_t             cfg_q;
  logic             go_rd;
  logic             go_wr;
  logic             halt;
  logic [SEL_W-1:0] tap;
  logic [PW-1:0]    pipe_out;

  assign go_rd = (cmd == CMD_RD);
  assign go_wr = (cmd == CMD_WR);
  assign halt  = (cmd == CMD_STOP) || (cmd == CMD_PRE);
  assign tap   = cfg_q.cas3 ? SEL_W'(2) : SEL_W'(1);

  colgen_mode_dec u_dec (
    .clk  (clk),
    .rst  (rst),
    .load (mode_load),
    .word (mode_word),
    .cfg  (cfg_q),
    .err  (mode_err)
  );

  colgen_seq #(.COL_W(COL_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .go_rd     (go_rd),
    .go_wr     (go_wr),
    .halt      (halt),
    .start_col (cmd_col),
    .cfg       (cfg_q),
    .col_addr  (col_addr),
    .col_valid (col_valid),
    .col_last  (col_last),
    .col_write (col_write)
  );

  colgen_lat_pipe #(.W(PW), .DEPTH(MAX_CL), .SEL_W(SEL_W)) u_lat (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (col_valid && !col_write),
    .in_dat  ({col_last, col_addr}),
    .tap     (tap),
    .out_vld (rd_valid),
    .out_dat (pipe_out)
  );

  assign rd_last = pipe_out[PW-1];
  assign rd_col  = pipe_out[COL_W-1:0];

endmodule

// File: rtl/colgen_chk.sv
module colgen_chk
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_load,
  input logic [CMD_W-1:0] cmd,
  input logic [COL_W-1:0] cmd_col,
  input logic [COL_W-1:0] col_addr,
  input logic             col_valid,
  input logic             col_last,
  input logic             col_write,
  input logic             rd_valid,
  input logic [COL_W-1:0] rd_col,
  input logic             mode_err,
  input logic             cas3,
  input logic             wr_one
);

  logic starts;
  logic stops;
  assign starts = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign stops  = (cmd == CMD_STOP) || (cmd == CMD_PRE);

  a_r4_first_beat: assert property (@(posedge clk) disable iff (rst)
    starts |=> (col_valid && col_addr == $past(cmd_col)));

  a_r8_end_after_last: assert property (@(posedge clk) disable iff (rst)
    (col_valid && col_last && !starts) |=> !col_valid);

  a_r11_halt: assert property (@(posedge clk) disable iff (rst)
    stops |=> !col_valid);

  a_r3_err_source: assert property (@(posedge clk) disable iff (rst)
    mode_err |-> $past(mode_load));

  a_r12_single_write: assert property (@(posedge clk) disable iff (rst)
    (col_valid && col_write && wr_one) |-> col_last);

  a_r13_cl2: assert property (@(posedge clk) disable iff (rst)
    (!cas3 && col_valid && !col_write) |=> ##1 (rd_valid && rd_col == $past(col_addr, 2)));

  a_r13_cl3: assert property (@(posedge clk) disable iff (rst)
    (cas3 && col_valid && !col_write) |=> ##2 (rd_valid && rd_col == $past(col_addr, 3)));

endmodule

bind sdr_burst_colgen colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode_load (mode_load),
  .cmd       (cmd),
  .cmd_col   (cmd_col),
  .col_addr  (col_addr),
  .col_valid (col_valid),
  .col_last  (col_last),
  .col_write (col_write),
  .rd_valid  (rd_valid),
  .rd_col    (rd_col),
  .mode_err  (mode_err),
  .cas3      (cfg_q.cas3),
  .wr_one    (cfg_q.wr_one)
);

// File: tb/test_sdr_burst_colgen.sv
module test_sdr_burst_colgen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_load = 1'b0;
  logic [9:0] mode_word = '0;
  logic [2:0] cmd = 3'd0;
  logic [7:0] cmd_col = '0;
  logic [7:0] col_addr;
  logic       col_valid, col_last, col_write;
  logic       rd_valid, rd_last, mode_err;
  logic [7:0] rd_col;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sdr_burst_colgen i_sdr_burst_colgen (
    .clk(clk), .rst(rst), .mode_load(mode_load), .mode_word(mode_word),
    .cmd(cmd), .cmd_col(cmd_col), .col_addr(col_addr), .col_valid(col_valid),
    .col_last(col_last), .col_write(col_write), .rd_valid(rd_valid),
    .rd_col(rd_col), .rd_last(rd_last), .mode_err(mode_err)
  );

  // rows: {mode word, command, start column}
  localparam int NROW = 9;
  localparam logic [20:0] ROWS [NROW] = '{
    {10'h023, 3'd1, 8'h45},   // len 8 seq CL2 read
    {10'h02B, 3'd1, 8'h12},   // len 8 interleave CL2 read
    {10'h032, 3'd1, 8'hA7},   // len 4 seq CL3 read
    {10'h03A, 3'd2, 8'h5E},   // len 4 interleave CL3 write
    {10'h021, 3'd2, 8'h33},   // len 2 seq write
    {10'h029, 3'd1, 8'hFF},   // len 2 interleave read
    {10'h020, 3'd1, 8'h77},   // len 1 read
    {10'h223, 3'd2, 8'h10},   // single-write mode, write
    {10'h223, 3'd1, 8'h10}    // single-write mode, read
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] beat(input logic [7:0] s, input int m,
                                      input logic [7:0] mask, input logic ilv);
    logic [7:0] low;
    low = ilv ? (s ^ 8'(m)) : (s + 8'(m));
    return (s & ~mask) | (low & mask);
  endfunction

  task automatic load_mode(input logic [9:0] w, input logic exp_err);
    mode_load = 1'b1;
    mode_word = w;
    @(negedge clk);
    mode_load = 1'b0;
    chk(mode_err == exp_err, exp_err ? "R3" : "R2", int'(mode_err), int'(exp_err));
    @(negedge clk);
    chk(mode_err == 1'b0, "R3", int'(mode_err), 0);
  endtask

  task automatic issue(input logic [2:0] c, input logic [7:0] col);
    cmd = c;
    cmd_col = col;
    @(negedge clk);
    cmd = 3'd0;
  endtask

  // eff: settings in force (R2 field positions); do_load: program them first
  task automatic run_check(input logic [9:0] eff, input logic do_load,
                           input logic [2:0] c, input logic [7:0] col);
    logic is_wr, is_rd, ilv;
    int blen, cl;
    logic [7:0] mask;
    is_wr = (c == 3'd2);
    is_rd = (c == 3'd1);
    ilv   = eff[3];
    cl    = (eff[6:4] == 3'b011) ? 3 : 2;
    blen  = (is_wr && eff[9]) ? 1 : (1 << eff[1:0]);
    mask  = 8'(blen - 1);
    if (do_load) load_mode(eff, 1'b0);
    issue(c, col);
    for (int m = 0; m <= blen + cl; m++) begin
      if (m < blen) begin
        chk(col_valid, "R4", int'(col_valid), 1);
        chk(col_addr == beat(col, m, mask, ilv), ilv ? "R6" : "R5",
            int'(col_addr), int'(beat(col, m, mask, ilv)));
        chk((col_addr & ~mask) == (col & ~mask), "R7", int'(col_addr), int'(col));
        chk(col_last == (m == blen - 1), "R8", int'(col_last), int'(m == blen - 1));
        chk(col_write == is_wr, "R4", int'(col_write), int'(is_wr));
        if (is_wr && eff[9]) chk(col_last, "R12", int'(col_last), 1);
      end else begin
        chk(!col_valid, "R8", int'(col_valid), 0);
      end
      if (is_rd && m >= cl && m - cl < blen) begin
        chk(rd_valid, "R13", int'(rd_valid), 1);
        chk(rd_col == beat(col, m - cl, mask, ilv), "R13",
            int'(rd_col), int'(beat(col, m - cl, mask, ilv)));
        chk(rd_last == (m - cl == blen - 1), "R13", int'(rd_last), int'(m - cl == blen - 1));
      end else begin
        chk(!rd_valid, "R13", int'(rd_valid), 0);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state and default settings
    repeat (4) @(negedge clk);
    chk(!col_valid && !rd_valid && !mode_err && !col_last, "R1",
        int'({col_valid, rd_valid, mode_err, col_last}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!col_valid && !rd_valid && !mode_err, "R1",
        int'({col_valid, rd_valid, mode_err}), 0);
    run_check(10'h020, 1'b0, 3'd1, 8'h09);

    // vector table
    for (int r = 0; r < NROW; r++) begin
      run_check(ROWS[r][20:11], 1'b1, ROWS[r][10:8], ROWS[r][7:0]);
    end

    // R3: rejected words leave len 2 seq CL2 in force
    load_mode(10'h021, 1'b0);
    load_mode(10'h024, 1'b1);
    load_mode(10'h02F, 1'b1);
    load_mode(10'h041, 1'b1);
    load_mode(10'h0A3, 1'b1);
    run_check(10'h021, 1'b0, 3'd1, 8'h35);

    // R9 full page wraps, no last; R11 precharge ends it
    load_mode(10'h027, 1'b0);
    issue(3'd1, 8'hFE);
    for (int m = 0; m < 260; m++) begin
      chk(col_valid && col_addr == 8'(8'hFE + m), "R9", int'(col_addr), int'(8'(8'hFE + m)));
      chk(!col_last, "R9", int'(col_last), 0);
      if (m < 259) @(negedge clk);
    end
    issue(3'd4, 8'h00);
    chk(!col_valid, "R11", int'(col_valid), 0);
    repeat (5) @(negedge clk);
    chk(!col_valid && !rd_valid, "R11", int'({col_valid, rd_valid}), 0);

    // R10 interrupt: read 0x40 len 8, write 0x83 after three beats
    load_mode(10'h023, 1'b0);
    issue(3'd1, 8'h40);
    @(negedge clk);
    @(negedge clk);
    chk(col_addr == 8'h42, "R10", int'(col_addr), 8'h42);
    issue(3'd2, 8'h83);
    for (int m = 0; m < 8; m++) begin
      chk(col_valid && col_write && col_addr == beat(8'h83, m, 8'h07, 1'b0), "R10",
          int'(col_addr), int'(beat(8'h83, m, 8'h07, 1'b0)));
      chk(col_last == (m == 7), "R10", int'(col_last), int'(m == 7));
      if (m == 2) chk(!rd_valid, "R13", int'(rd_valid), 0);
      @(negedge clk);
    end
    chk(!col_valid, "R10", int'(col_valid), 0);

    // R11 burst stop during a write
    issue(3'd2, 8'h20);
    @(negedge clk);
    chk(col_addr == 8'h21, "R11", int'(col_addr), 8'h21);
    @(negedge clk);
    issue(3'd3, 8'h00);
    chk(!col_valid, "R11", int'(col_valid), 0);
    repeat (3) @(negedge clk);
    chk(!col_valid, "R11", int'(col_valid), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule